// File: doc/BRIEF.md
# Offload Kick Dispatch Tracker

This block sits between a small control processor and a set of offload pipelines. The core hands it one request at a time. A request is either a kick or a barrier. A kick names one pipeline and carries a control-stream base address taken from a core register. The tracker launches that pipeline with a one-cycle start pulse. It holds the address on that pipeline's address lines and marks the pipeline busy until the pipeline returns a done pulse.

Kicks do not block the core, so several pipelines can run at once. Each pipeline accepts only one outstanding kick. A kick aimed at a pipeline that is still running holds the core through `stall_o` until that pipeline reports done. A barrier holds the core until no pipeline is busy. The core keeps its request steady on the inputs for as long as `stall_o` is high. A cycle in which `req_valid_i` is high and `stall_o` is low retires the request.

Top module: `kick_tracker`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `pipe_busy_o`, `pipe_start_o` and `stall_o` are all zero.
- R2: A kick (`req_op_i` = 0) to an idle pipeline retires with `stall_o` low. In the next cycle that pipeline's `pipe_start_o` bit is high for exactly one cycle, its `pipe_busy_o` bit is high, and its `pipe_addr_o` entry equals the request address.
- R3: Kicks to different pipelines in consecutive cycles all retire without stall, and their busy bits are set together.
- R4: A kick to a busy pipeline that sees no done pulse in the same cycle drives `stall_o` high, produces no start pulse and leaves every busy bit unchanged.
- R5: A done pulse on `pipe_done_i[p]` while pipeline p is busy clears `pipe_busy_o[p]` in the next cycle.
- R6: If pipeline p is busy and a done pulse and a kick for p fall in the same cycle, the kick retires with `stall_o` low, `pipe_busy_o[p]` stays high and a new start pulse follows in the next cycle.
- R7: A barrier (`req_op_i` = 1) presented while no pipeline is busy retires with `stall_o` low.
- R8: A barrier keeps `stall_o` high while any busy bit is set. `stall_o` falls in the cycle after the last done pulse.
- R9: A done pulse on a pipeline that is not busy has no effect on any busy bit.
- R10: A kick whose pipeline index is `N_PIPE` or greater retires without stall and changes no start, busy or address output.
- R11: Each `pipe_addr_o` entry holds the address of the last kick accepted for that pipeline until the next accepted kick for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core presents a request |
| req_op_i | input | 1 | 0 = kick, 1 = barrier |
| req_pipe_i | input | PIPE_W | Target pipeline index for a kick |
| req_addr_i | input | ADDR_W | Control-stream base address for a kick |
| stall_o | output | 1 | Core must hold the current request |
| pipe_start_o | output | N_PIPE | One-cycle launch pulse per pipeline |
| pipe_addr_o | output | N_PIPE x ADDR_W | Base address held per pipeline |
| pipe_done_i | input | N_PIPE | One-cycle completion pulse per pipeline |
| pipe_busy_o | output | N_PIPE | Pipeline has a kick in flight |

## Verification
`stall_o` is combinational from the request and the registered busy state, so the bench samples it in the middle of the cycle in which the request is driven. Start pulses, busy bits and addresses are registered, so they are due one edge after the request or done pulse that caused them. The bench reads them just after that edge, before the next stimulus is applied. The barrier release is checked by a chain of cycles. The done pulse appears in one cycle, and the stall is expected to be low in the cycle after it.

// File: rtl/kick_pkg.sv
package kick_pkg;
  typedef enum logic {
    OP_KICK    = 1'b0,
    OP_BARRIER = 1'b1
  } kick_op_e;
endpackage

// File: rtl/kick_decode.sv
module kick_decode
  import kick_pkg::*;
#(
  parameter int unsigned N_PIPE = 3,
  parameter int unsigned PIPE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  kick_op_e          req_op_i,
  input  logic [PIPE_W-1:0] req_pipe_i,
  input  logic [N_PIPE-1:0] busy_i,
  input  logic [N_PIPE-1:0] done_i,
  output logic [N_PIPE-1:0] accept_o,
  output logic              stall_o
);

  logic              is_kick;
  logic              is_bar;
  logic              in_range;
  logic [N_PIPE-1:0] hit;
  logic [N_PIPE-1:0] blocked;
  logic              kick_stall;
  logic              bar_stall;

  assign is_kick  = req_valid_i && (req_op_i == OP_KICK);
  assign is_bar   = req_valid_i && (req_op_i == OP_BARRIER);
  assign in_range = 32'(req_pipe_i) < N_PIPE;

  for (genvar i = 0; i < N_PIPE; i++) begin : g_hit
    assign hit[i]     = in_range && (req_pipe_i == PIPE_W'(i));
    // a done in the same cycle frees the slot for the waiting kick
    assign blocked[i] = hit[i] && busy_i[i] && !done_i[i];
  end

  assign kick_stall = is_kick && (|blocked);
  assign bar_stall  = is_bar && (|busy_i);
  assign stall_o    = kick_stall || bar_stall;
  assign accept_o   = (is_kick && !kick_stall) ? hit : '0;

  AST_ACCEPT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(accept_o)); // R3
  AST_NO_ACCEPT_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (accept_o == '0)); // R4
  AST_BARRIER_IDLE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_bar && (busy_i == '0)) |-> !stall_o); // R7
  AST_RANGE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_kick && !in_range) |-> (!stall_o && accept_o == '0)); // R10

endmodule

// File: rtl/kick_slot.sv
module kick_slot #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              start_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              busy_q;
  logic              start_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      busy_q  <= accept_i || (busy_q && !done_i);
      start_q <= accept_i;
      if (accept_i) addr_q <= addr_i;
    end
  end

  assign start_o = start_q;
  assign busy_o  = busy_q;
  assign addr_o  = addr_q;

  AST_START_MARKS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> busy_q); // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> busy_q); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i && !accept_i) |=> !busy_q); // R5
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && done_i && !accept_i) |=> !busy_q); // R9
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(addr_q)); // R11

endmodule

// File: rtl/kick_tracker.sv
module kick_tracker
  import kick_pkg::*;
#(
  parameter  int unsigned N_PIPE = 3,
  parameter  int unsigned ADDR_W = 8,
  localparam int unsigned PIPE_W = (N_PIPE > 1) ? $clog2(N_PIPE) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  input  logic                           req_op_i,
  input  logic [PIPE_W-1:0]              req_pipe_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  output logic                           stall_o,
  output logic [N_PIPE-1:0]              pipe_start_o,
  output logic [N_PIPE-1:0][ADDR_W-1:0]  pipe_addr_o,
  input  logic [N_PIPE-1:0]              pipe_done_i,
  output logic [N_PIPE-1:0]              pipe_busy_o
);

  logic [N_PIPE-1:0] accept;
  logic [N_PIPE-1:0] busy;
  kick_op_e          op;

  assign op = kick_op_e'(req_op_i);

  kick_decode #(
    .N_PIPE(N_PIPE),
    .PIPE_W(PIPE_W)
  ) i_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_op_i   (op),
    .req_pipe_i (req_pipe_i),
    .busy_i     (busy),
    .done_i     (pipe_done_i),
    .accept_o   (accept),
    .stall_o    (stall_o)
  );

  for (genvar i = 0; i < N_PIPE; i++) begin : g_slot
    kick_slot #(
      .ADDR_W(ADDR_W)
    ) i_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .accept_i(accept[i]),
      .done_i  (pipe_done_i[i]),
      .addr_i  (req_addr_i),
      .start_o (pipe_start_o[i]),
      .busy_o  (busy[i]),
      .addr_o  (pipe_addr_o[i])
    );
  end

  assign pipe_busy_o = busy;

  AST_BARRIER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && req_op_i && (busy == '0)) |-> 1'b0); // R8
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_start_o != '0) |-> ((pipe_start_o & ~busy) == '0)); // R2

endmodule

// File: tb/test_kick_tracker.sv
module test_kick_tracker;
  localparam int N = 3;
  localparam int AW = 8;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic          op = 1'b0;
  logic [1:0]    pipe = '0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  done = '0;
  logic          stall;
  logic [N-1:0]  start;
  logic [N-1:0][AW-1:0] paddr;
  logic [N-1:0]  busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  kick_tracker #(.N_PIPE(N), .ADDR_W(AW)) i_kick_tracker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_op_i(op),
    .req_pipe_i(pipe), .req_addr_i(addr), .stall_o(stall),
    .pipe_start_o(start), .pipe_addr_o(paddr), .pipe_done_i(done),
    .pipe_busy_o(busy)
  );

  // {valid, op, pipe[2], addr[8], done[3], exp_stall, exp_start[3], exp_busy[3]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0, 8'h11, 3'b000, 1'b0, 3'b001, 3'b001}, // R2 kick p0
    {1'b1, 1'b0, 2'd1, 8'h22, 3'b000, 1'b0, 3'b010, 3'b011}, // R3 kick p1
    {1'b1, 1'b0, 2'd0, 8'h33, 3'b000, 1'b1, 3'b000, 3'b011}, // R4 p0 busy
    {1'b1, 1'b0, 2'd0, 8'h33, 3'b001, 1'b0, 3'b001, 3'b011}, // R6 done+kick
    {1'b1, 1'b1, 2'd0, 8'h00, 3'b000, 1'b1, 3'b000, 3'b011}, // R8 barrier
    {1'b1, 1'b1, 2'd0, 8'h00, 3'b010, 1'b1, 3'b000, 3'b001}, // R5 R8 p1 done
    {1'b1, 1'b1, 2'd0, 8'h00, 3'b001, 1'b1, 3'b000, 3'b000}, // R8 last done
    {1'b1, 1'b1, 2'd0, 8'h00, 3'b000, 1'b0, 3'b000, 3'b000}, // R8 released
    {1'b0, 1'b0, 2'd0, 8'h00, 3'b100, 1'b0, 3'b000, 3'b000}, // R9 idle done
    {1'b1, 1'b0, 2'd3, 8'h44, 3'b000, 1'b0, 3'b000, 3'b000}, // R10 bad index
    {1'b1, 1'b0, 2'd2, 8'h55, 3'b000, 1'b0, 3'b100, 3'b100}, // R2 kick p2
    {1'b0, 1'b0, 2'd0, 8'h00, 3'b100, 1'b0, 3'b000, 3'b000}  // R5 p2 done
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 start in reset", 32'(start), 0);
    chk("R1 stall in reset", 32'(stall), 0);
    rst_n = 1'b1;
    step();
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 stall after reset", 32'(stall), 0);

    for (int k = 0; k < NV; k++) begin
      logic [21:0] v;
      v = VEC[k];
      valid = v[21];
      op    = v[20];
      pipe  = v[19:18];
      addr  = v[17:10];
      done  = v[9:7];
      @(negedge clk);
      chk($sformatf("R4/R6/R7/R8 stall vec %0d", k), 32'(stall), 32'(v[6]));
      step();
      chk($sformatf("R2/R10 start vec %0d", k), 32'(start), 32'(v[5:3]));
      chk($sformatf("R3/R5/R9 busy vec %0d", k), 32'(busy), 32'(v[2:0]));
      if (v[5:3] != 3'b000)
        chk($sformatf("R2 address vec %0d", k), 32'(paddr[v[19:18]]), 32'(v[17:10]));
    end
    valid = 1'b0;
    done  = '0;

    // R11: addresses held from last accepted kicks; R10 value never landed
    chk("R11 addr p0", 32'(paddr[0]), 32'h33);
    chk("R11 addr p1", 32'(paddr[1]), 32'h22);
    chk("R11 addr p2", 32'(paddr[2]), 32'h55);

    // R2: start lasts a single cycle
    valid = 1'b1; op = 1'b0; pipe = 2'd1; addr = 8'h66;
    step();
    valid = 1'b0;
    chk("R2 start pulse", 32'(start), 32'b010);
    step();
    chk("R2 start drops", 32'(start), 0);
    chk("R2 busy holds", 32'(busy), 32'b010);

    // R7: barrier with nothing busy never stalls (separate from release)
    done = 3'b010;
    step();
    done = '0;
    valid = 1'b1; op = 1'b1;
    @(negedge clk);
    chk("R7 idle barrier", 32'(stall), 0);
    step();
    valid = 1'b0;

    // R1: reset mid-run clears busy
    valid = 1'b1; op = 1'b0; pipe = 2'd0; addr = 8'h77;
    step();
    valid = 1'b0;
    chk("R2 busy before reset", 32'(busy), 32'b001);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear busy", 32'(busy), 0);
    chk("R1 async clear start", 32'(start), 0);
    step();
    rst_n = 1'b1;
    step();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule